// File: doc/BRIEF.md
# Colour Lookup Table Write Port

This block holds a 256-entry colour palette and gives a host a byte-wide path into it through only two registers. The host picks an entry by writing the index register, then writes the data register three times in a row: the first byte supplies red, the second green, the third blue. A small phase state machine tracks which component comes next, so one data register serves all three components. After the blue byte the entry index steps forward by one, so a whole palette can be streamed after a single index write.

Red and green are held in staging registers and the entry is written to storage only when blue arrives, so the display side never reads a half-updated colour. A separate pixel port turns an 8-bit pixel index into a 12-bit colour triple one clock later, with no dependence on host traffic. The host can also read the palette back through the same data register, walking through the components in the same order as for a write.

Phase state machine: states `PH_RED`, `PH_GRN`, `PH_BLU`. Transitions: any index write goes to `PH_RED` (LOAD); a data access goes `PH_RED`→`PH_GRN` (STEP_R), `PH_GRN`→`PH_BLU` (STEP_G), and `PH_BLU`→`PH_RED` with index increment (WRAP_B); with no access the state holds (IDLE).

Top module: `clut_port`

## Requirements
- R1: After reset the entry index is 0 and the phase is red, so data writes without a prior index write fill entry 0 starting with red.
- R2: A host write with `host_sel`=0 loads the entry index from `host_wdata` and returns the phase to red, discarding any partly written components.
- R3: Host writes with `host_sel`=1 fill red, green and blue in that order; each component is `host_wdata[7:4]`, and bits [3:0] are ignored.
- R4: An entry is written to storage only on the blue write; after only the red and green writes the pixel port still returns the old colour.
- R5: After the blue access the entry index increments by one (255 wraps to 0) and the phase returns to red.
- R6: `pix_rgb` = {red, green, blue} (red in bits [11:8], blue in [3:0]) of the entry selected by `pix_idx` on the previous clock edge, regardless of host activity.
- R7: A host read with `host_sel`=1 returns the current-phase component of the current entry in `host_rdata[7:4]` with [3:0] zero, and advances phase and index exactly as a data write does.
- R8: A host read with `host_sel`=0 returns the current entry index.
- R9: When `host_wr` and `host_rd` are both high, the write is performed and `host_rdata` is left unchanged.
- R10: `host_rdata` changes only on the clock edge that samples a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Register select: 0 index, 1 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after the strobe |
| pix_idx | input | 8 | Pixel palette index |
| pix_rgb | output | 12 | Colour of the indexed entry, one clock later |

## Verification
A wrong phase shows up on the next data access as a component landing in the wrong colour field, visible one cycle after the blue write at the pixel port or immediately on a component readback. A wrong index shows as a colour appearing at a neighbouring entry or as a bad value on the next index readback, one cycle after the read strobe. An early commit is caught by looking up the entry between the green and blue writes, where the old colour must still be present.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int NUM_COMP = 3;
endpackage

// File: rtl/clut_phase_fsm.sv
module clut_phase_fsm
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_load,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             data_acc,
    input  logic             data_wr,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             stage_r,
    output logic             stage_g,
    output logic             commit
);
    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (idx_load) begin
            phase_d = PH_RED;
            idx_d   = idx_val;
        end else if (data_acc) begin
            unique case (phase_q)
                PH_RED:  phase_d = PH_GRN;
                PH_GRN:  phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + IDX_W'(1);
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    // outputs
    always_comb begin
        stage_r = 1'b0;
        stage_g = 1'b0;
        commit  = 1'b0;
        unique case (phase_q)
            PH_RED:  stage_r = data_wr;
            PH_GRN:  stage_g = data_wr;
            PH_BLU:  commit  = data_wr;
            default: ;
        endcase
    end

    assign phase = phase_q;
    assign idx   = idx_q;
endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 4
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [3*COMP_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0]    host_idx,
    output logic [3*COMP_W-1:0] host_rgb,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int WORD_W  = 3 * COMP_W;

    logic [WORD_W-1:0] mem [ENTRIES];
    logic [WORD_W-1:0] pix_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_rgb;
    end

    always_ff @(posedge clk) begin
        pix_q <= mem[pix_idx];
    end

    assign host_rgb = mem[host_idx];
    assign pix_rgb  = pix_q;
endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 4,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic                host_sel,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    localparam int WORD_W = NUM_COMP * COMP_W;
    localparam int PAD_W  = BYTE_W - COMP_W;

    logic              idx_load, data_acc, data_wr, rd_en;
    logic              stage_r, stage_g, commit;
    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic [COMP_W-1:0] in_comp, red_q, grn_q;
    logic [WORD_W-1:0] host_rgb;
    logic [COMP_W-1:0] comp [NUM_COMP];
    logic [BYTE_W-1:0] rd_byte, rdata_q;

    assign idx_load = host_wr && !host_sel;
    assign data_wr  = host_wr && host_sel;
    assign data_acc = host_sel && (host_wr || host_rd);
    assign rd_en    = host_rd && !host_wr;
    assign in_comp  = host_wdata[BYTE_W-1 -: COMP_W];

    clut_phase_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .idx_val  (host_wdata[IDX_W-1:0]),
        .data_acc (data_acc),
        .data_wr  (data_wr),
        .phase    (phase),
        .idx      (idx),
        .stage_r  (stage_r),
        .stage_g  (stage_g),
        .commit   (commit)
    );

    always_ff @(posedge clk) begin
        if (stage_r) red_q <= in_comp;
        if (stage_g) grn_q <= in_comp;
    end

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk      (clk),
        .wr_en    (commit),
        .wr_idx   (idx),
        .wr_rgb   ({red_q, grn_q, in_comp}),
        .host_idx (idx),
        .host_rgb (host_rgb),
        .pix_idx  (pix_idx),
        .pix_rgb  (pix_rgb)
    );

    // split stored word into components, red first
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
        assign comp[k] = host_rgb[(NUM_COMP-k)*COMP_W-1 -: COMP_W];
    end

    always_comb begin
        rd_byte = BYTE_W'(idx);
        if (host_sel) begin
            unique case (phase)
                PH_RED:  rd_byte = {comp[0], {PAD_W{1'b0}}};
                PH_GRN:  rd_byte = {comp[1], {PAD_W{1'b0}}};
                PH_BLU:  rd_byte = {comp[2], {PAD_W{1'b0}}};
                default: rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_byte;
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 4,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_wr,
    input logic                host_rd,
    input logic                host_sel,
    input logic [BYTE_W-1:0]   host_rdata,
    input logic [IDX_W-1:0]    pix_idx,
    input logic [3*COMP_W-1:0] pix_rgb,
    input phase_e              phase,
    input logic [IDX_W-1:0]    idx
);
    localparam int PAD_W = BYTE_W - COMP_W;

    AST_INDEX_LOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel) |=> (phase == PH_RED)); // R2

    AST_BLUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && (host_wr || host_rd) && phase == PH_BLU)
        |=> (idx == $past(idx) + IDX_W'(1)) && (phase == PH_RED)); // R5

    AST_PIX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(host_wr) && $stable(pix_idx)) |=> $stable(pix_rgb)); // R6

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel) |=> (host_rdata[PAD_W-1:0] == '0)); // R7

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |=> $stable(host_rdata)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R10
endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_rdata (host_rdata),
    .pix_idx    (pix_idx),
    .pix_rgb    (pix_rgb),
    .phase      (phase),
    .idx        (idx)
);

// File: tb/tb_clut_port.sv
`timescale 1ns/1ps
module tb_clut_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [11:0] pix_rgb;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clut_port dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one host cycle, entered and left at a falling edge
    task automatic bus(input logic w, input logic r, input logic s, input logic [7:0] d);
        host_wr = w; host_rd = r; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        bus(1'b1, 1'b0, 1'b0, i);
    endtask

    task automatic put(input logic [7:0] d);
        bus(1'b1, 1'b0, 1'b1, d);
    endtask

    task automatic get(input logic s, output logic [7:0] v);
        bus(1'b0, 1'b1, s, 8'h00);
        v = host_rdata;
    endtask

    task automatic look(input logic [7:0] i, output logic [11:0] v);
        pix_idx = i;
        @(negedge clk);
        v = pix_rgb;
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [11:0] c;
        check("R10 reset rdata", host_rdata, 0);
        get(1'b0, b);
        check("R1 R8 index after reset", b, 0);
        put(8'hA0); put(8'hB5); put(8'hC0);
        look(8'd0, c);
        check("R1 R3 entry0 filled", c, 12'hABC);
    endtask

    task automatic t_commit_on_blue();
        logic [11:0] c;
        set_idx(8'd5); put(8'h10); put(8'h20); put(8'h30);
        look(8'd5, c);
        check("R3 entry5 first load", c, 12'h123);
        set_idx(8'd5); put(8'h90); put(8'h80);
        look(8'd5, c);
        check("R4 no commit before blue", c, 12'h123);
        put(8'h70);
        look(8'd5, c);
        check("R4 commit on blue", c, 12'h987);
    endtask

    task automatic t_index_midseq();
        logic [11:0] c;
        set_idx(8'd7); put(8'h40); put(8'h50); put(8'h60);
        set_idx(8'd7); put(8'hF0);
        set_idx(8'd7); put(8'h10); put(8'h20); put(8'h30);
        look(8'd7, c);
        check("R2 index write restarts at red", c, 12'h123);
        put(8'h4F); put(8'h5F); put(8'h6F);
        look(8'd8, c);
        check("R5 stream into next entry", c, 12'h456);
        look(8'd7, c);
        check("R5 previous entry kept", c, 12'h123);
    endtask

    task automatic t_wrap();
        logic [7:0] b; logic [11:0] c;
        set_idx(8'd255); put(8'hE0); put(8'hD0); put(8'hC0);
        get(1'b0, b);
        check("R5 index wraps to 0", b, 0);
        look(8'd255, c);
        check("R5 entry255 filled", c, 12'hEDC);
    endtask

    task automatic t_readback();
        logic [7:0] b;
        set_idx(8'd5);
        get(1'b1, b); check("R7 read red", b, 8'h90);
        get(1'b1, b); check("R7 read green", b, 8'h80);
        get(1'b1, b); check("R7 read blue", b, 8'h70);
        get(1'b0, b); check("R7 R8 index after blue read", b, 6);
        set_idx(8'd0);
        get(1'b1, b); check("R7 entry0 red", b, 8'hA0);
        get(1'b1, b); check("R3 low nibble dropped", b, 8'hB0);
    endtask

    task automatic t_collision();
        logic [7:0] b; logic [11:0] c;
        set_idx(8'd0);
        get(1'b0, b); check("R8 index 0", b, 0);
        bus(1'b1, 1'b1, 1'b1, 8'h50);
        check("R9 rdata held on collision", host_rdata, 0);
        put(8'h60); put(8'h70);
        look(8'd0, c);
        check("R9 collided write taken", c, 12'h567);
        get(1'b0, b); check("R8 index 1", b, 1);
        repeat (3) @(negedge clk);
        check("R10 rdata holds when idle", host_rdata, 1);
    endtask

    task automatic t_pixel_timing();
        logic [11:0] c;
        look(8'd8, c);
        pix_idx = 8'd5;
        #2;
        check("R6 output not combinational", pix_rgb, 12'h456);
        @(negedge clk);
        check("R6 one-cycle lookup", pix_rgb, 12'h987);
        // host writes to another entry do not disturb the lookup
        host_wr = 1'b1; host_sel = 1'b0; host_wdata = 8'd40;
        pix_idx = 8'd7;
        @(negedge clk);
        check("R6 lookup during host write", pix_rgb, 12'h123);
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit_on_blue();
        t_index_midseq();
        t_wrap();
        t_readback();
        t_collision();
        t_pixel_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule